// File: doc/BRIEF.md
# Partitioned Packed Adder

This block adds two 64-bit operands as one wide integer or as a group of narrower integers that share the word. A 2-bit width select picks eight 8-bit lanes, four 16-bit lanes, two 32-bit lanes or one 64-bit lane. Every lane wraps modulo two to the power of its width. No lane's carry reaches its neighbour.

There is only one ripple chain, built from eight byte-wide adder slices. Between each pair of adjacent slices sits a small gate. The gate passes the lower slice's carry up when both bytes belong to the same lane. It forces the upper carry-in to zero when the boundary is a lane edge.

Alongside the packed sum the block returns an 8-bit carry vector, with one bit per byte position. A bit is set only at the most significant byte of an active lane, and only when that lane overflowed. An optional output register, on by default, adds one cycle of latency. The reset is asserted asynchronously and released in step with the clock.

Top module: `packed_lane_adder`

## Requirements
- R1: The width select encodes 2'b00 as eight 8-bit lanes, 2'b01 as four 16-bit lanes, 2'b10 as two 32-bit lanes and 2'b11 as one 64-bit lane. Lane k occupies bits [k*W +: W], and its sum is (a_k + b_k) mod 2^W.
- R2: In 8-bit mode no carry crosses any byte boundary. For example, 8'hFF + 8'h01 in byte 0 gives 8'h00 there and leaves byte 1 equal to its own sum.
- R3: In 16-bit mode carries propagate from byte 0 into byte 1 within a lane. They never cross bit 15/16, 31/32 or 47/48.
- R4: In 32-bit mode carries ripple through bytes 0 to 3 and through bytes 4 to 7, but never across bit 31/32.
- R5: In 64-bit mode the carry ripples through all eight bytes, so the block acts as one 64-bit adder.
- R6: Bit i of the carry vector is the carry out of byte i when byte i is the top byte of an active lane (bytes 7 in 64-bit mode; 3,7 in 32-bit; 1,3,5,7 in 16-bit; all in 8-bit). Every other bit is 0.
- R7: With the output register enabled, the sum and carry outputs reflect the operands and mode sampled at the previous rising clock edge. While reset is active, both outputs are zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for the output register and the reset synchronizer |
| rst_n | input | 1 | Active-low reset, asserted asynchronously and released synchronously |
| lane_mode_i | input | 2 | Lane width select (00: 8, 01: 16, 10: 32, 11: 64 bits) |
| op_a_i | input | 64 | First packed operand |
| op_b_i | input | 64 | Second packed operand |
| sum_o | output | 64 | Packed wraparound sum |
| carry_o | output | 8 | Per-byte carry-out, non-zero only at lane top bytes |

## Verification
On every cycle, the embedded properties check that the carry into each byte is cut at every lane boundary that the current mode defines. In 64-bit mode they check that the carry into each byte equals the carry out of the byte below. They also check that no carry bit appears below the top byte in 64-bit mode, and that the registered outputs trail the combinational result by exactly one edge. The arithmetic values themselves are shown only by the bench's scenarios. Those scenarios compare each lane against a separate per-lane model for all-ones operands, a single carry injected at a boundary, random operands in every mode, and mode changes between consecutive cycles.

// File: rtl/packed_lane_pkg.sv
package packed_lane_pkg;

  localparam int unsigned DATA_W = 64;
  localparam int unsigned BYTE_W = 8;
  localparam int unsigned NUM_BYTES = DATA_W / BYTE_W;

  typedef enum logic [1:0] {
    LM_B8  = 2'b00,
    LM_H16 = 2'b01,
    LM_W32 = 2'b10,
    LM_D64 = 2'b11
  } lane_mode_e;

  // Bit i set when i is a multiple of step (byte index at a lane bottom).
  function automatic logic [NUM_BYTES-1:0] lane_base_mask(input int unsigned step);
    logic [NUM_BYTES-1:0] m;
    m = '0;
    for (int unsigned i = 0; i < NUM_BYTES; i++) begin
      if ((i % step) == 0) m[i] = 1'b1;
    end
    return m;
  endfunction

endpackage

// File: rtl/byte_add_slice.sv
module byte_add_slice #(
  parameter int unsigned W = 8
) (
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  input  logic         cin_i,
  output logic [W-1:0] sum_o,
  output logic         cout_o
);

  logic [W:0] total;

  always_comb begin
    total  = {1'b0, a_i} + {1'b0, b_i} + {{W{1'b0}}, cin_i};
    sum_o  = total[W-1:0];
    cout_o = total[W];
  end

endmodule

// File: rtl/lane_boundary_gate.sv
module lane_boundary_gate
  import packed_lane_pkg::*;
#(
  parameter int unsigned BYTE_IDX = 0
) (
  input  lane_mode_e mode_i,
  input  logic       carry_lo_i,   // carry out of this byte
  output logic       is_top_o,     // this byte closes its lane
  output logic       carry_up_o    // carry handed to the next byte
);

  localparam int unsigned IW = $clog2(NUM_BYTES) + 2;
  localparam logic [IW-1:0] POS = IW'(BYTE_IDX + 1);

  logic [IW-1:0] span_m1;

  always_comb begin
    span_m1    = (IW'(1) << mode_i) - IW'(1);
    is_top_o   = ((POS & span_m1) == '0);
    carry_up_o = carry_lo_i & ~is_top_o;
  end

endmodule

// File: rtl/packed_lane_adder.sv
module packed_lane_adder
  import packed_lane_pkg::*;
#(
  parameter bit REG_OUT = 1'b1
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [1:0]           lane_mode_i,
  input  logic [DATA_W-1:0]    op_a_i,
  input  logic [DATA_W-1:0]    op_b_i,
  output logic [DATA_W-1:0]    sum_o,
  output logic [NUM_BYTES-1:0] carry_o
);

  localparam logic [NUM_BYTES-1:0] BASE_H16 = lane_base_mask(2);
  localparam logic [NUM_BYTES-1:0] BASE_W32 = lane_base_mask(4);

  lane_mode_e mode;
  assign mode = lane_mode_e'(lane_mode_i);

  // Reset: asynchronous assertion, clocked release.
  logic rst_meta_q, rst_sync_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_sync_n <= rst_meta_q;
    end
  end

  // Segmented ripple chain.
  logic [DATA_W-1:0]    sum_c;
  logic [NUM_BYTES-1:0] raw_co, lane_top, cin_vec, carry_c;

  for (genvar i = 0; i < NUM_BYTES; i++) begin : g_byte
    logic cin_b, co_b, top_b, up_b;
    logic [BYTE_W-1:0] s_b;

    if (i == 0) begin : g_first
      assign cin_b = 1'b0;
    end else begin : g_link
      assign cin_b = g_byte[i-1].up_b;
    end

    byte_add_slice #(.W(BYTE_W)) i_slice (
      .a_i    (op_a_i[i*BYTE_W +: BYTE_W]),
      .b_i    (op_b_i[i*BYTE_W +: BYTE_W]),
      .cin_i  (cin_b),
      .sum_o  (s_b),
      .cout_o (co_b)
    );

    lane_boundary_gate #(.BYTE_IDX(i)) i_gate (
      .mode_i     (mode),
      .carry_lo_i (co_b),
      .is_top_o   (top_b),
      .carry_up_o (up_b)
    );

    assign sum_c[i*BYTE_W +: BYTE_W] = s_b;
    assign raw_co[i]   = co_b;
    assign lane_top[i] = top_b;
    assign cin_vec[i]  = cin_b;
    assign carry_c[i]  = co_b & top_b;
  end

  // Optional output stage.
  if (REG_OUT) begin : g_reg
    logic [DATA_W-1:0]    sum_d, sum_q;
    logic [NUM_BYTES-1:0] carry_d, carry_q;

    always_comb begin
      sum_d   = sum_c;
      carry_d = carry_c;
    end

    always_ff @(posedge clk or negedge rst_sync_n) begin
      if (!rst_sync_n) begin
        sum_q   <= '0;
        carry_q <= '0;
      end else begin
        sum_q   <= sum_d;
        carry_q <= carry_d;
      end
    end

    assign sum_o   = sum_q;
    assign carry_o = carry_q;

    // R7: outputs trail the combinational result by one edge
    a_r7_one_cycle: assert property (@(posedge clk) disable iff (!rst_sync_n)
      $past(rst_sync_n) |-> (sum_o == $past(sum_c) && carry_o == $past(carry_c)));
  end else begin : g_comb
    assign sum_o   = sum_c;
    assign carry_o = carry_c;
  end

  // R2: every byte boundary is cut in 8-bit mode
  a_r2_byte_cut: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (mode == LM_B8) |-> (cin_vec == '0));

  // R3: lane bottoms of 16-bit lanes get no carry
  a_r3_half_cut: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (mode == LM_H16) |-> ((cin_vec & BASE_H16) == '0));

  // R4: lane bottoms of 32-bit lanes get no carry
  a_r4_word_cut: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (mode == LM_W32) |-> ((cin_vec & BASE_W32) == '0));

  // R5: full ripple through all bytes in 64-bit mode
  a_r5_full_chain: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (mode == LM_D64) |-> (cin_vec[NUM_BYTES-1:1] == raw_co[NUM_BYTES-2:0]));

  // R6: only the top byte may report a carry in 64-bit mode
  a_r6_top_only: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (mode == LM_D64) |-> (carry_c[NUM_BYTES-2:0] == '0));

endmodule

// File: tb/test_packed_lane_adder.sv
`timescale 1ns/1ps
module test_packed_lane_adder;

  logic        clk;
  logic        rst_n;
  logic [1:0]  mode;
  logic [63:0] a, b;
  logic [63:0] sum;
  logic [7:0]  co;

  int checks = 0;
  int errors = 0;
  bit done   = 0;

  packed_lane_adder i_packed_lane_adder (
    .clk(clk), .rst_n(rst_n), .lane_mode_i(mode),
    .op_a_i(a), .op_b_i(b), .sum_o(sum), .carry_o(co)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;   // 50 MHz

  function automatic string mode_tag(input logic [1:0] m);
    case (m)
      2'b00: return "R2";
      2'b01: return "R3";
      2'b10: return "R4";
      default: return "R5";
    endcase
  endfunction

  // Per-lane reference model.
  task automatic ref_add(input logic [63:0] x, input logic [63:0] y,
                         input logic [1:0] m,
                         output logic [63:0] s, output logic [7:0] c);
    int w;
    logic [64:0] msk, xl, yl, t;
    w = 8 << m;
    s = '0; c = '0;
    msk = (65'd1 << w) - 65'd1;
    for (int l = 0; l < 64 / w; l++) begin
      xl = ({1'b0, x} >> (l * w)) & msk;
      yl = ({1'b0, y} >> (l * w)) & msk;
      t  = xl + yl;
      s  = s | 64'((t & msk) << (l * w));
      c[(l * w + w) / 8 - 1] = t[w];
    end
  endtask

  task automatic check64(input string tag, input logic [63:0] got, input logic [63:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  // Drive at a falling edge, sample at the next falling edge (one register).
  task automatic apply_check(input logic [63:0] x, input logic [63:0] y, input logic [1:0] m);
    logic [63:0] es; logic [7:0] ec;
    @(negedge clk);
    a = x; b = y; mode = m;
    @(negedge clk);
    ref_add(x, y, m, es, ec);
    check64({"R1/", mode_tag(m), " sum"}, sum, es);
    check64("R6 carry", {56'd0, co}, {56'd0, ec});
  endtask

  task automatic t_reset;
    rst_n = 1'b0; a = '1; b = '1; mode = 2'b11;
    repeat (3) @(negedge clk);
    check64("R7 reset sum", sum, 64'd0);
    check64("R7 reset carry", {56'd0, co}, 64'd0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
  endtask

  task automatic t_all_ones;
    for (int m = 0; m < 4; m++) begin
      apply_check('1, '1, 2'(m));
      apply_check('1, 64'h0101_0101_0101_0101, 2'(m));
    end
  endtask

  task automatic t_boundary;
    // byte 0 overflows; in R2 mode byte 1 must stay 0
    apply_check(64'h0000_0000_0000_00FF, 64'h0000_0000_0000_0001, 2'b00);
    check64("R2 byte1 isolated", {56'd0, sum[15:8]}, 64'd0);
    apply_check(64'h0000_0000_0000_00FF, 64'h0000_0000_0000_0001, 2'b01);
    check64("R3 carry into byte1", sum, 64'h0000_0000_0000_0100);
    apply_check(64'h0000_0000_FFFF_FFFF, 64'h0000_0000_0000_0001, 2'b10);
    check64("R4 no cross at bit32", sum, 64'd0);
    check64("R6 word carry", {56'd0, co}, 64'h08);
    apply_check(64'h0000_0000_FFFF_FFFF, 64'h0000_0000_0000_0001, 2'b11);
    check64("R5 cross bit32", sum, 64'h0000_0001_0000_0000);
    apply_check('1, 64'd1, 2'b11);
    check64("R6 quad carry", {56'd0, co}, 64'h80);
  endtask

  task automatic t_random;
    for (int m = 0; m < 4; m++)
      for (int n = 0; n < 40; n++)
        apply_check({$urandom, $urandom}, {$urandom, $urandom}, 2'(m));
  endtask

  task automatic t_latency;
    logic [63:0] prev, es; logic [7:0] ec;
    apply_check(64'h1234, 64'h1, 2'b11);
    prev = sum;
    @(negedge clk);
    a = 64'hFFFF; b = 64'h1; mode = 2'b00;
    #2;
    check64("R7 holds before edge", sum, prev);
    @(negedge clk);
    ref_add(64'hFFFF, 64'h1, 2'b00, es, ec);
    check64("R7 updates after edge", sum, es);
  endtask

  task automatic finish_run;
    if (!done) begin
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  initial begin
    #4000000;
    checks++; errors++;
    $display("FAIL watchdog: got timeout expected completion");
    finish_run();
  end

  initial begin
    t_reset();
    t_all_ones();
    t_boundary();
    t_random();
    t_latency();
    finish_run();
  end

endmodule